// File: doc/BRIEF.md
# Processor Interrupt Pending Controller

This block keeps the eight interrupt-pending bits of a processor's cause register and decides whether the pipeline should take an interrupt exception. Software or platform logic posts or clears one line per cycle through a request port that carries a line index and an operation bit. A separate strobe wipes every pending bit at once. A built-in comparison of the cycle counter against its compare register raises the line picked by a 3-bit select field.

The take-interrupt request is a combinational function of the held pending bits and the status inputs: global enable, error level, exception level and the 8-bit mask. A raw any-pending flag reports the pending bits whatever the status inputs are. An out-of-range line index is dropped and flagged in the same cycle.

Top module: `irq_pend_ctrl`

## Requirements
- R1: While rst_ni is low, and at the first clock after it is released, pending_o is 0 and any_pend_o and take_irq_o are 0.
- R2: A request with req_valid_i=1, req_op_i=0 (post) and legal index n (0..7) sets pending_o[n] at the next rising edge. No other bit is cleared.
- R3: A request with req_valid_i=1, req_op_i=1 (clear) and legal index n clears pending_o[n] at the next rising edge. No other bit is changed, unless a post source targets it.
- R4: A request whose req_idx_i is 8 or above leaves pending_o unchanged. idx_err_o is 1 in that cycle. idx_err_o is 0 in any cycle without such a request.
- R5: clr_all_i=1 makes pending_o zero at the next edge. This overrides a post request and a timer match in the same cycle.
- R6: A timer match occurs when count_i equals compare_i and count_i is not zero. A match sets pending_o[tmr_sel_i] at the next edge. Equal values of zero never set a bit.
- R7: A clear request for line n wins over a timer match that selects n in the same cycle, so bit n ends up 0.
- R8: any_pend_o is 1 exactly when pending_o is nonzero, independent of ie_i, erl_i, exl_i and mask_i.
- R9: take_irq_o is 1 exactly when ie_i=1, erl_i=0, exl_i=0, mask_i is nonzero and pending_o is nonzero.
- R10: In a cycle with no valid request, no clear-all and no timer match, pending_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Post/clear request valid |
| req_op_i | input | 1 | 0 = post, 1 = clear |
| req_idx_i | input | 4 | Line index of the request |
| clr_all_i | input | 1 | Clear every pending bit |
| ie_i | input | 1 | Global interrupt enable |
| erl_i | input | 1 | Error level |
| exl_i | input | 1 | Exception level |
| mask_i | input | 8 | Interrupt mask field |
| count_i | input | 32 | Cycle counter value |
| compare_i | input | 32 | Timer compare value |
| tmr_sel_i | input | 3 | Pending line raised by a timer match |
| pending_o | output | 8 | Pending field |
| any_pend_o | output | 1 | Pending field nonzero |
| take_irq_o | output | 1 | Take-interrupt request to the pipeline |
| idx_err_o | output | 1 | Illegal line index in this cycle |

## Verification
The assertions treat every input as sampled once per rising edge, and they accept any combination of request, clear-all and timer match in one cycle. In a cycle where a timer match could also set a bit, they read the clear and post outcomes only for the line the request names. The stimulus changes inputs only on falling edges. It holds count_i and compare_i unequal, or both at zero, except in the cycles meant to produce a match. This keeps each post, clear and illegal-index step free of timer side effects.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  typedef enum logic {
    OP_POST  = 1'b0,
    OP_CLEAR = 1'b1
  } req_op_e;
endpackage

// File: rtl/irq_req_decode.sv
module irq_req_decode
  import irq_pend_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 4
) (
  input  logic                 valid_i,
  input  logic                 op_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_LINES-1:0] set_o,
  output logic [NUM_LINES-1:0] clr_o,
  output logic                 err_o
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_LINES);

  req_op_e op;
  logic    legal;

  assign op    = req_op_e'(op_i);
  assign legal = ({1'b0, idx_i} < LIMIT);
  assign err_o = valid_i && !legal;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic hit;
    assign hit      = valid_i && (idx_i == IDX_W'(g));
    assign set_o[g] = hit && (op == OP_POST);
    assign clr_o[g] = hit && (op == OP_CLEAR);
  end
endmodule

// File: rtl/irq_timer_match.sv
module irq_timer_match #(
  parameter int NUM_LINES = 8,
  parameter int SEL_W     = 3,
  parameter int CNT_W     = 32
) (
  input  logic [CNT_W-1:0]     count_i,
  input  logic [CNT_W-1:0]     compare_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic                 match_o,
  output logic [NUM_LINES-1:0] set_o
);
  assign match_o = (count_i == compare_i) && (count_i != '0);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sel
    assign set_o[g] = match_o && (sel_i == SEL_W'(g));
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] set_i,
  input  logic [NUM_LINES-1:0] clr_i,
  input  logic                 clr_all_i,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] pend_q, pend_d;

  // priority: clear-all > per-line clear > any set source
  always_comb begin
    if (clr_all_i) pend_d = '0;
    else           pend_d = (pend_q | set_i) & ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_take_logic.sv
module irq_take_logic #(
  parameter int NUM_LINES = 8
) (
  input  logic                 ie_i,
  input  logic                 erl_i,
  input  logic                 exl_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic [NUM_LINES-1:0] pend_i,
  output logic                 any_o,
  output logic                 take_o
);
  logic armed;

  assign any_o  = |pend_i;
  assign armed  = ie_i && !erl_i && !exl_i;
  // mask and pending are tested as whole fields, not bit by bit
  assign take_o = armed && (|mask_i) && any_o;
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 4,
  parameter int SEL_W     = 3,
  parameter int CNT_W     = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_op_i,
  input  logic [IDX_W-1:0]     req_idx_i,
  input  logic                 clr_all_i,
  input  logic                 ie_i,
  input  logic                 erl_i,
  input  logic                 exl_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic [CNT_W-1:0]     count_i,
  input  logic [CNT_W-1:0]     compare_i,
  input  logic [SEL_W-1:0]     tmr_sel_i,
  output logic [NUM_LINES-1:0] pending_o,
  output logic                 any_pend_o,
  output logic                 take_irq_o,
  output logic                 idx_err_o
);
  logic [NUM_LINES-1:0] req_set, req_clr, tmr_set;
  logic                 tmr_match;

  irq_req_decode #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_dec (
    .valid_i (req_valid_i),
    .op_i    (req_op_i),
    .idx_i   (req_idx_i),
    .set_o   (req_set),
    .clr_o   (req_clr),
    .err_o   (idx_err_o)
  );

  irq_timer_match #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_tmr (
    .count_i   (count_i),
    .compare_i (compare_i),
    .sel_i     (tmr_sel_i),
    .match_o   (tmr_match),
    .set_o     (tmr_set)
  );

  irq_pend_reg #(.NUM_LINES(NUM_LINES)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (req_set | tmr_set),
    .clr_i     (req_clr),
    .clr_all_i (clr_all_i),
    .pend_o    (pending_o)
  );

  irq_take_logic #(.NUM_LINES(NUM_LINES)) u_take (
    .ie_i   (ie_i),
    .erl_i  (erl_i),
    .exl_i  (exl_i),
    .mask_i (mask_i),
    .pend_i (pending_o),
    .any_o  (any_pend_o),
    .take_o (take_irq_o)
  );

  logic unused_match;
  assign unused_match = tmr_match;
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 4,
  parameter int SEL_W     = 3,
  parameter int CNT_W     = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_op_i,
  input logic [IDX_W-1:0]     req_idx_i,
  input logic                 clr_all_i,
  input logic                 ie_i,
  input logic                 erl_i,
  input logic                 exl_i,
  input logic [NUM_LINES-1:0] mask_i,
  input logic [CNT_W-1:0]     count_i,
  input logic [CNT_W-1:0]     compare_i,
  input logic [SEL_W-1:0]     tmr_sel_i,
  input logic [NUM_LINES-1:0] pending_o,
  input logic                 any_pend_o,
  input logic                 take_irq_o,
  input logic                 idx_err_o
);
  localparam int LW = $clog2(NUM_LINES);

  logic legal, hit_match, is_post, is_clear;
  assign legal     = int'(req_idx_i) < NUM_LINES;
  assign hit_match = (count_i == compare_i) && (count_i != '0);
  assign is_post   = req_valid_i && !req_op_i && legal;
  assign is_clear  = req_valid_i && req_op_i && legal;

  p_post_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_post && !clr_all_i |=>
      pending_o[$past(req_idx_i[LW-1:0])] &&
      ((pending_o & $past(pending_o)) == $past(pending_o)));

  p_clear_line_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_clear |=> !pending_o[$past(req_idx_i[LW-1:0])]);

  p_bad_idx_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !legal && !clr_all_i && !hit_match |=> $stable(pending_o));

  p_bad_idx_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_err_o |-> req_valid_i && !legal);

  p_clr_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> pending_o == '0);

  p_timer_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_match && !clr_all_i && !(is_clear && (int'(req_idx_i) == int'(tmr_sel_i)))
      |=> pending_o[$past(tmr_sel_i)]);

  p_clear_beats_timer_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_match && is_clear && (int'(req_idx_i) == int'(tmr_sel_i))
      |=> !pending_o[$past(tmr_sel_i)]);

  p_any_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_pend_o == ($countones(pending_o) != 0));

  p_take_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> ie_i && !erl_i && !exl_i && (mask_i != '0) && any_pend_o);

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i && !clr_all_i && !hit_match |=> $stable(pending_o));
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .SEL_W(SEL_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
  .req_idx_i(req_idx_i), .clr_all_i(clr_all_i), .ie_i(ie_i), .erl_i(erl_i),
  .exl_i(exl_i), .mask_i(mask_i), .count_i(count_i), .compare_i(compare_i),
  .tmr_sel_i(tmr_sel_i), .pending_o(pending_o), .any_pend_o(any_pend_o),
  .take_irq_o(take_irq_o), .idx_err_o(idx_err_o)
);

// File: tb/sim_irq_pend_ctrl.sv
`timescale 1ns/1ps
module sim_irq_pend_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_op_i = 1'b0, clr_all_i = 1'b0;
  logic [3:0]  req_idx_i = '0;
  logic        ie_i = 1'b0, erl_i = 1'b0, exl_i = 1'b0;
  logic [7:0]  mask_i = '0;
  logic [31:0] count_i = '0, compare_i = '0;
  logic [2:0]  tmr_sel_i = '0;
  logic [7:0]  pending_o;
  logic        any_pend_o, take_irq_o, idx_err_o;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] model = '0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  irq_pend_ctrl u0 (
    .clk_i, .rst_ni, .req_valid_i, .req_op_i, .req_idx_i, .clr_all_i,
    .ie_i, .erl_i, .exl_i, .mask_i, .count_i, .compare_i, .tmr_sel_i,
    .pending_o, .any_pend_o, .take_irq_o, .idx_err_o
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: act %0d cycles exp under 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  // expected status-dependent outputs from the model
  function automatic logic exp_take(logic [7:0] p);
    return ie_i && !erl_i && !exl_i && (mask_i != 0) && (p != 0);
  endfunction

  // one cycle: drive at falling edge, check flag, step model, check after edge
  task automatic step(string req, logic v, logic op, logic [3:0] idx, logic ca,
                      logic [31:0] cnt, logic [31:0] cmp, logic [2:0] sel);
    logic [7:0] setm, clrm;
    logic bad;
    req_valid_i = v; req_op_i = op; req_idx_i = idx; clr_all_i = ca;
    count_i = cnt; compare_i = cmp; tmr_sel_i = sel;
    #1;
    bad = v && (idx > 4'd7);
    chk({req, " R4 err flag"}, 32'(idx_err_o), 32'(bad));
    setm = '0; clrm = '0;
    if (v && !bad) begin
      if (op) clrm[idx[2:0]] = 1'b1;
      else    setm[idx[2:0]] = 1'b1;
    end
    if (cnt == cmp && cnt != 0) setm[sel] = 1'b1;
    model = ca ? 8'h00 : ((model | setm) & ~clrm);
    @(negedge clk_i);
    chk(req, 32'(pending_o), 32'(model));
    chk({req, " R8"}, 32'(any_pend_o), 32'(model != 0));
    chk({req, " R9"}, 32'(take_irq_o), 32'(exp_take(model)));
  endtask

  task automatic idle(string req);
    step(req, 0, 0, 0, 0, 32'd5, 32'd9, 0);
  endtask

  initial begin
    @(negedge clk_i); #1;
    // R1: in reset
    chk("R1 reset pending", 32'(pending_o), 0);
    chk("R1 reset any", 32'(any_pend_o), 0);
    chk("R1 reset take", 32'(take_irq_o), 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", 32'(pending_o), 0);

    ie_i = 1; mask_i = 8'h01;
    // R2/R3/R4: sweep every index 0..15 with post then clear, from two backgrounds
    for (int bg = 0; bg < 2; bg++) begin
      step("R5 setup clear-all", 0, 0, 0, 1, 0, 0, 0);
      if (bg == 1) for (int k = 0; k < 8; k += 2) step("R2 bg post", 1, 0, 4'(k), 0, 0, 0, 0);
      for (int i = 0; i < 16; i++) begin
        step(i < 8 ? "R2 post" : "R4 illegal post", 1, 0, 4'(i), 0, 0, 0, 0);
        step(i < 8 ? "R3 clear" : "R4 illegal clear", 1, 1, 4'(i), 0, 0, 0, 0);
        idle("R10 idle hold");
      end
    end

    // R5: clear-all overrides post and timer
    for (int i = 0; i < 8; i++) step("R2 fill", 1, 0, 4'(i), 0, 0, 0, 0);
    step("R5 clear-all vs post+timer", 1, 0, 4'd3, 1, 32'd7, 32'd7, 3'd5);
    chk("R5 zero", 32'(pending_o), 0);

    // R6: timer sweep over every select value
    for (int s = 0; s < 8; s++) begin
      step("R6 timer match", 0, 0, 0, 0, 32'(100 + s), 32'(100 + s), 3'(s));
      step("R6 no match", 0, 0, 0, 0, 32'(100 + s), 32'(101 + s), 3'(s));
    end
    step("R5 clear-all", 0, 0, 0, 1, 0, 0, 0);
    step("R6 zero count no match", 0, 0, 0, 0, 32'd0, 32'd0, 3'd4);
    chk("R6 zero count", 32'(pending_o), 0);

    // R7: clear beats timer on same line; other line both apply
    for (int s = 0; s < 8; s++) begin
      step("R7 preset", 1, 0, 4'(s), 0, 0, 0, 0);
      step("R7 clear vs timer", 1, 1, 4'(s), 0, 32'd33, 32'd33, 3'(s));
      step("R7 clear one, timer other", 1, 1, 4'(s), 0, 32'd33, 32'd33, 3'((s + 1) % 8));
    end

    // R8/R9: exhaustive over status bits, mask classes, pending empty/non-empty
    for (int pe = 0; pe < 2; pe++) begin
      step("R5 clear-all", 0, 0, 0, 1, 0, 0, 0);
      if (pe == 1) step("R2 post line 6", 1, 0, 4'd6, 0, 0, 0, 0);
      for (int st = 0; st < 8; st++) begin
        for (int m = 0; m < 4; m++) begin
          ie_i = st[0]; erl_i = st[1]; exl_i = st[2];
          mask_i = (m == 0) ? 8'h00 : (m == 1) ? 8'h01 : (m == 2) ? 8'h80 : 8'hff;
          #1;
          chk("R8 any vs status", 32'(any_pend_o), 32'(pe));
          chk("R9 take", 32'(take_irq_o),
              32'(st[0] && !st[1] && !st[2] && m != 0 && pe == 1));
          @(negedge clk_i);
        end
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule